// File: doc/BRIEF.md
# Compare Timer Channel

This block is a single timer channel that sits on a simple synchronous register bus. Software programs a compare value and a mode, then writes a start trigger. The channel counts input clock ticks, and it pulses an interrupt output whenever the count equals the compare value. A separate stop trigger halts counting. A read-only run-status register lets software confirm that a start or a stop has taken effect.

There are two modes. In periodic mode the counter goes from zero up to the compare value and then reloads to zero, so a compare value of N-1 gives one interrupt every N ticks. In free-running mode the counter counts up through its whole range and wraps. It interrupts once each time it passes the compare value. Software can stop the channel on that interrupt to get a one-shot event. The count can be read at any time. Software is expected to change compare and mode only while the channel is stopped.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset the channel is stopped, the compare, count and mode registers are zero, `irq_o` is low and `bus_rdata` is zero.
- R2: Compare sits at byte offset 0x000 and is read/write. It is CNT_W bits wide (default 32). Each write updates only the bytes whose `bus_be` bit is set. Bits above CNT_W read as zero.
- R3: Control sits at offset 0x020. A write with `bus_be[0]` set loads bit 1 as the mode: 0 selects periodic and 1 selects free-running. Bit 1 reads back and every other bit reads as zero.
- R4: A write to offset 0x014 with `bus_be[0]` and data bit 0 both set starts the channel. At the next edge the run status becomes 1 and the count becomes 0, and this also happens when the channel is already running. A write with data bit 0 clear has no effect.
- R5: A write to offset 0x018 with `bus_be[0]` and data bit 0 both set stops the channel. Offset 0x010 reads the run status in bit 0, with all other bits zero.
- R6: In periodic mode the running count steps 0, 1, ... up to the compare value and then returns to 0, so interrupts come every compare+1 ticks. A compare value of 0 gives an interrupt every tick.
- R7: In free-running mode the running count adds one per tick and wraps from 2^CNT_W-1 to 0.
- R8: `irq_o` is high in exactly those cycles where the channel is running and the count equals the compare value. It is never high while the channel is stopped.
- R9: While the channel is stopped, the count holds its value and stays readable at offset 0x004.
- R10: Writes to the count (0x004) and status (0x010) offsets change nothing. Reads of the trigger offsets and of unmapped offsets return zero.
- R11: Reads are registered. `bus_rdata` after an edge shows the register at `bus_addr` as it was before that edge, and this also holds in a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_be | input | DATA_W/8 | Byte enables for writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Compare event pulse |

## Verification
A wrong count or run state shows at the ports within one cycle. `irq_o` depends directly on both, and the bench reads the count register on every idle cycle, so any stray increment, missed reload or missed hold shows up in the next read. A stale mode or compare value shows up at the first compare event, because that event comes at the wrong tick. A mishandled wrap only shows up after 2^CNT_W ticks, so the bench uses a narrower counter to reach the wrap within the run.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam logic [7:0] OFS_CMP  = 8'h00;
  localparam logic [7:0] OFS_CNT  = 8'h04;
  localparam logic [7:0] OFS_RUN  = 8'h10;
  localparam logic [7:0] OFS_GO   = 8'h14;
  localparam logic [7:0] OFS_HALT = 8'h18;
  localparam logic [7:0] OFS_CTRL = 8'h20;

  localparam int TRIG_BIT = 0;
  localparam int MODE_BIT = 1;

  typedef enum logic {
    MODE_PERIODIC = 1'b0,
    MODE_FREERUN  = 1'b1
  } mode_e;
endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic                run_i,
  output logic [CNT_W-1:0]    cmp_o,
  output mode_e               mode_o,
  output logic                go_o,
  output logic                halt_o,
  output logic [DATA_W-1:0]   bus_rdata
);
  localparam int BE_W = DATA_W / 8;

  logic sel_cmp, sel_cnt, sel_run, sel_go, sel_halt, sel_ctrl;
  logic [DATA_W-1:0] lane_mask;
  logic [CNT_W-1:0]  cmp_q, cmp_d;
  mode_e             mode_q, mode_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              cmp_en, mode_en;

  assign sel_cmp  = (bus_addr == ADDR_W'(OFS_CMP));
  assign sel_cnt  = (bus_addr == ADDR_W'(OFS_CNT));
  assign sel_run  = (bus_addr == ADDR_W'(OFS_RUN));
  assign sel_go   = (bus_addr == ADDR_W'(OFS_GO));
  assign sel_halt = (bus_addr == ADDR_W'(OFS_HALT));
  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign lane_mask[8*b +: 8] = {8{bus_be[b]}};
  end

  assign go_o   = bus_we && sel_go   && bus_be[0] && bus_wdata[TRIG_BIT];
  assign halt_o = bus_we && sel_halt && bus_be[0] && bus_wdata[TRIG_BIT];

  assign cmp_en  = bus_we && sel_cmp;
  assign mode_en = bus_we && sel_ctrl && bus_be[0];

  always_comb begin
    cmp_d  = (cmp_q & ~lane_mask[CNT_W-1:0]) |
             (bus_wdata[CNT_W-1:0] & lane_mask[CNT_W-1:0]);
    mode_d = mode_e'(bus_wdata[MODE_BIT]);
  end

  always_comb begin
    rdata_d = '0;
    if (sel_cmp)  rdata_d[CNT_W-1:0]  = cmp_q;
    if (sel_cnt)  rdata_d[CNT_W-1:0]  = cnt_i;
    if (sel_run)  rdata_d[TRIG_BIT]   = run_i;
    if (sel_ctrl) rdata_d[MODE_BIT]   = mode_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q   <= '0;
      mode_q  <= MODE_PERIODIC;
      rdata_q <= '0;
    end else begin
      if (cmp_en)  cmp_q  <= cmp_d;
      if (mode_en) mode_q <= mode_d;
      rdata_q <= rdata_d;
    end
  end

  assign cmp_o     = cmp_q;
  assign mode_o    = mode_q;
  assign bus_rdata = rdata_q;

  // R2: compare changes only through its own offset
  a_r2_cmp_own_offset: assert property (@(posedge clk) disable iff (!rst_ni)
    !(bus_we && sel_cmp) |=> $stable(cmp_q));

  // R5: status read carries nothing above bit 0
  a_r5_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    sel_run |=> (bus_rdata[DATA_W-1:1] == '0));
endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             halt_i,
  input  mode_e            mode_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             match;

  assign match = (cnt_q == cmp_i);

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (go_i) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (halt_i) begin
      run_d = 1'b0;
    end else if (run_q) begin
      if (mode_i == MODE_PERIODIC && match) cnt_d = '0;
      else                                  cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
  assign irq_o = run_q && match;

  // R4: start yields a running channel at count zero
  a_r4_go_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    go_i |=> (run_q && cnt_q == '0));

  // R5: stop without start leaves the channel idle
  a_r5_halt_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    (halt_i && !go_i) |=> !run_q);

  // R6: periodic reload after the compare tick
  a_r6_periodic_reload: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_q && !go_i && !halt_i && mode_i == MODE_PERIODIC && cnt_q == cmp_i)
      |=> (cnt_q == '0));

  // R7: free-running step of one per tick
  a_r7_freerun_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_q && !go_i && !halt_i && mode_i == MODE_FREERUN)
      |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R9: stopped count stays put
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run_q && !go_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_o
);
  logic [1:0]       rsync_q;
  logic             rst_sync_n;
  logic [CNT_W-1:0] cmp_w, cnt_w;
  mode_e            mode_w;
  logic             go_w, halt_w, run_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  cmp_timer_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_ni(rst_sync_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .cnt_i(cnt_w), .run_i(run_w),
    .cmp_o(cmp_w), .mode_o(mode_w), .go_o(go_w), .halt_o(halt_w),
    .bus_rdata(bus_rdata)
  );

  cmp_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_ni(rst_sync_n),
    .go_i(go_w), .halt_i(halt_w), .mode_i(mode_w), .cmp_i(cmp_w),
    .cnt_o(cnt_w), .run_o(run_w), .irq_o(irq_o)
  );

  // R8: no event pulse while stopped, seen at the port
  a_r8_quiet_stopped: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (halt_w && !go_w) |=> !irq_o);
endmodule

// File: tb/cmp_timer_chan_test.sv
`timescale 1ns/1ps
module cmp_timer_chan_test;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int CW = 12;
  localparam logic [31:0] MASK = (32'd1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [3:0]    bus_be = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  bit done = 0;

  bit          m_run = 0;
  bit          m_mode = 0;
  logic [31:0] m_cnt = '0;
  logic [31:0] m_cmp = '0;

  always #2 clk = ~clk;

  cmp_timer_chan #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00:   return m_cmp;
      8'h04:   return m_cnt;
      8'h10:   return {31'b0, m_run};
      8'h20:   return {30'b0, m_mode, 1'b0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic cyc(input logic [7:0] a, input bit we, input logic [3:0] be,
                     input logic [31:0] wd, input string tag);
    logic [31:0] exp_rd;
    bit exp_irq, go, halt;
    bus_addr = a; bus_we = we; bus_be = be; bus_wdata = wd;
    exp_irq = m_run && (m_cnt == m_cmp);
    chk(irq_o == exp_irq, tag, {31'b0, irq_o}, {31'b0, exp_irq});
    if (irq_o) irq_seen++;
    exp_rd = model_read(a);
    go   = we && be[0] && wd[0] && (a == 8'h14);
    halt = we && be[0] && wd[0] && (a == 8'h18);
    if (go) begin
      m_run = 1; m_cnt = 0;
    end else if (halt) begin
      m_run = 0;
    end else if (m_run) begin
      if (!m_mode && m_cnt == m_cmp) m_cnt = 0;
      else m_cnt = (m_cnt + 1) & MASK;
    end
    if (we && a == 8'h00) begin
      for (int b = 0; b < 4; b++) if (be[b]) m_cmp[8*b +: 8] = wd[8*b +: 8];
      m_cmp = m_cmp & MASK;
    end
    if (we && a == 8'h20 && be[0]) m_mode = wd[1];
    @(posedge clk); #1;
    chk(bus_rdata == exp_rd, tag, bus_rdata, exp_rd);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(8'h04, 0, 4'h0, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(bus_rdata == 0, "R1", bus_rdata, 0);
    chk(irq_o == 0, "R1", {31'b0, irq_o}, 0);
    cyc(8'h00, 0, 4'h0, 0, "R1");
    cyc(8'h04, 0, 4'h0, 0, "R1");
    cyc(8'h10, 0, 4'h0, 0, "R1");
    cyc(8'h20, 0, 4'h0, 0, "R1");
    cyc(8'h20, 0, 4'h0, 0, "R1");

    // R2: byte-lane writes of compare
    cyc(8'h00, 1, 4'b0010, 32'hA5A5_1234, "R2");
    cyc(8'h00, 0, 4'h0, 0, "R2");
    cyc(8'h00, 1, 4'b0001, 32'hFFFF_FF56, "R2");
    cyc(8'h00, 0, 4'h0, 0, "R2");
    cyc(8'h00, 0, 4'h0, 0, "R2");

    // R3: control keeps only the mode bit
    cyc(8'h20, 1, 4'hF, 32'hFFFF_FFFF, "R3");
    cyc(8'h20, 0, 4'h0, 0, "R3");
    cyc(8'h20, 1, 4'b1110, 32'h0, "R3");
    cyc(8'h20, 0, 4'h0, 0, "R3");
    cyc(8'h20, 1, 4'h1, 32'h0, "R3");
    cyc(8'h20, 0, 4'h0, 0, "R3");

    // R4: trigger with bit 0 clear does nothing
    cyc(8'h14, 1, 4'h1, 32'hFFFF_FFFE, "R4");
    cyc(8'h10, 0, 4'h0, 0, "R4");
    idle(3, "R4");

    // R6: periodic with compare 4 gives period 5
    cyc(8'h00, 1, 4'hF, 32'd4, "R6");
    cyc(8'h14, 1, 4'h1, 32'h1, "R6");
    cyc(8'h10, 0, 4'h0, 0, "R5");
    irq_seen = 0;
    idle(25, "R6");
    chk(irq_seen == 5, "R6", irq_seen, 5);

    // R5, R8, R9: stop, poll status, count holds, no pulses
    cyc(8'h18, 1, 4'h1, 32'h1, "R5");
    cyc(8'h10, 0, 4'h0, 0, "R5");
    irq_seen = 0;
    idle(8, "R9");
    chk(irq_seen == 0, "R8", irq_seen, 0);

    // R10: writes to count and status ignored, trigger reads zero
    cyc(8'h04, 1, 4'hF, 32'h0000_0ABC, "R10");
    cyc(8'h10, 1, 4'hF, 32'hFFFF_FFFF, "R10");
    cyc(8'h04, 0, 4'h0, 0, "R10");
    cyc(8'h10, 0, 4'h0, 0, "R10");
    cyc(8'h14, 0, 4'h0, 0, "R10");
    cyc(8'h18, 0, 4'h0, 0, "R10");
    cyc(8'h3C, 0, 4'h0, 0, "R10");
    cyc(8'h08, 0, 4'h0, 0, "R10");

    // R6: compare 0 pulses every tick
    cyc(8'h00, 1, 4'hF, 32'd0, "R6");
    cyc(8'h14, 1, 4'h1, 32'h1, "R6");
    irq_seen = 0;
    idle(6, "R6");
    chk(irq_seen == 6, "R6", irq_seen, 6);

    // R4: restart while running, R11 read during write
    cyc(8'h00, 1, 4'hF, 32'd9, "R11");
    idle(4, "R4");
    cyc(8'h14, 1, 4'h1, 32'h1, "R4");
    idle(3, "R4");
    cyc(8'h18, 1, 4'h1, 32'h1, "R11");

    // R7: free-running, one event per wrap
    cyc(8'h20, 1, 4'h1, 32'h2, "R7");
    cyc(8'h00, 1, 4'hF, 32'd5, "R7");
    cyc(8'h14, 1, 4'h1, 32'h1, "R7");
    irq_seen = 0;
    idle((1 << CW) + 10, "R7");
    chk(irq_seen == 2, "R7", irq_seen, 2);

    // R8: one-shot use, stop right at the event
    cyc(8'h14, 1, 4'h1, 32'h1, "R8");
    idle(5, "R8");
    chk(irq_o == 1, "R8", {31'b0, irq_o}, 1);
    cyc(8'h18, 1, 4'h1, 32'h1, "R8");
    irq_seen = 0;
    idle(6, "R8");
    chk(irq_seen == 0, "R8", irq_seen, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule